// File: doc/BRIEF.md
# Single-page instruction fetch buffer

This block sits between an instruction sequencer and the address translation path. It keeps the translation of one logical code page, the page the program counter is running in, and that page's physical base. While the PC stays in that page, a 16-bit or 32-bit instruction fetch gets its physical word addresses without a new translation. When the PC leaves the page, or the stored entry is no longer valid, the block sends one translation request, refills its single entry from the response, and then finishes the fetch.

The stored tag holds the logical page number and a root-select code. Root-select tells which translation root was in use for the page. A spare root-select code marks the entry as empty. The entry is emptied at reset, on a translation flush, on any write to a translation-control register, and after a failed translation. Each physical word address is then decoded into a RAM offset, a ROM offset or a bus error. The sequencer sees one done pulse per fetch. That pulse carries up to two mapped word addresses and the status flags.

Top module: `fetch_page_buffer`

## Requirements
- R1: A fetch whose page (PC with the low `pageShift` bits cleared) and root-select both equal the stored tag raises no translation request. Its word address is the stored physical base with the offset bits replaced by the PC's offset bits.
- R2: A miss raises `xlReqValid` for exactly one cycle, with `xlReqAddr` equal to the word address being looked up. `xlReqFc` is 6 when the fetch is in supervisor mode and 2 in user mode. A good response refills the tag, and the fetch then completes from the refilled entry.
- R3: Root-select is 1 when `supRootEn` is 1 and the fetch is in supervisor mode, and 0 otherwise. A fetch whose root-select differs from the stored one misses even in the same page. With `supRootEn` 0, user and supervisor fetches share one entry.
- R4: Reset, a `ctrlWrite` pulse and a `flushPulse` pulse each set the stored root-select to the code 2. No lookup can produce that code, so the next translated fetch misses.
- R5: A 32-bit fetch is split when its last byte lies past the end of the page, that is when ((PC & mask) + 3) >> pageShift is nonzero. In that case the words at PC and PC+2 are looked up separately, and each may miss. Otherwise one lookup serves both words, and the second word is the first plus 2.
- R6: A fetch from an odd PC ends with `doneAddrErr` set. It raises no translation request, both word addresses are zero, and the stored tag is unchanged.
- R7: With `xlatEnable` at 0, the PC and PC+2 are used directly as physical word addresses. No request is raised and the stored entry is not used.
- R8: A physical word address below 0x40000000 maps to RAM: the word's rom flag is 0 and its address is the physical address modulo `RAM_BYTES`. An address from 0x40000000 to 0x4FFFFFFF maps to ROM: the rom flag is 1 and the address is the physical address ANDed with `ROM_BYTES`-1. Any higher address sets `doneBusErr`, and that word's address and rom flag read 0.
- R9: A translation response with `xlRespAbort` set ends the fetch with `doneAbort` set. All word addresses and flags other than `doneAbort` read 0, and the entry is left empty, so the next fetch misses.
- R10: The offset mask is (1 << `pageShift`) - 1. It follows `pageShift` whenever that input changes.
- R11: `fetchReady` is high only while no fetch is in progress. `doneValid` is a one-cycle pulse per accepted fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xlatEnable | input | 1 | Address translation enabled |
| supRootEn | input | 1 | Supervisor fetches use the separate supervisor root |
| pageShift | input | PS_W | Log2 of the page size in bytes |
| ctrlWrite | input | 1 | Pulse: a translation-control register was written |
| flushPulse | input | 1 | Pulse: translation caches flushed |
| fetchValid | input | 1 | Fetch request |
| fetchReady | output | 1 | Block is idle and accepts a fetch |
| fetchPc | input | ADDR_W | Logical PC of the fetch |
| fetchLong | input | 1 | 1 = 32-bit fetch, 0 = 16-bit fetch |
| superMode | input | 1 | Fetch is in supervisor mode |
| xlReqValid | output | 1 | Translation request |
| xlReqAddr | output | ADDR_W | Logical word address to translate |
| xlReqFc | output | 3 | Function code of the request (6 or 2) |
| xlRespValid | input | 1 | Translation response |
| xlRespAbort | input | 1 | Translation failed |
| xlRespBase | input | ADDR_W | Physical address of the page (offset bits ignored) |
| doneValid | output | 1 | Fetch result pulse |
| doneAddrErr | output | 1 | Odd PC |
| doneAbort | output | 1 | Translation failed |
| doneBusErr | output | 1 | A word fell outside RAM and ROM |
| doneRom0 | output | 1 | First word is in ROM |
| doneAddr0 | output | ADDR_W | Mapped address of the first word |
| doneRom1 | output | 1 | Second word is in ROM (32-bit fetch) |
| doneAddr1 | output | ADDR_W | Mapped address of the second word (32-bit fetch) |

## Verification
The bench uses the default parameters. `RAM_BYTES` is 0x300000, which is not a power of two, so a translated address above the installed RAM shows a true modulo wrap rather than a truncation. `ROM_BYTES` is 0x40000, so ROM addresses fold onto a 256 KiB window. `pageShift` is driven at 12 and then at 8. With the smaller page, a 32-bit fetch near the end of a page splits into two lookups, and the same PC that is not split under 12 confirms that the mask follows the input. The translation responder builds different physical bases for user and supervisor codes. As a result, the shared entry that `supRootEn` = 0 allows shows up as a supervisor ROM translation reused by a user fetch.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_DONE
  } fpb_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;       // latch a new fetch
    logic captureCur;   // store mapped address of current word
    logic captureNext;  // store mapped address of current word + 2 as word 1
    logic advance;      // move to the second word of a split fetch
    logic refill;       // load tag from the translation response
    logic dropTag;      // empty the entry (failed translation)
    logic markOdd;      // flag an odd PC
    logic markAbort;    // flag a failed translation
  } fpb_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic oddPc;
    logic hit;
    logic crossing;
    logic isLong;
    logic secondHalf;
  } fpb_status_t;

  localparam logic [1:0] ROOT_EMPTY    = 2'd2;
  localparam logic [2:0] FC_SUPER_CODE = 3'd6;
  localparam logic [2:0] FC_USER_CODE  = 3'd2;

endpackage

// File: rtl/fpb_region_map.sv
module fpb_region_map #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RAM_BYTES = ADDR_W'(32'h0030_0000),
  parameter logic [ADDR_W-1:0] ROM_BYTES = ADDR_W'(32'h0004_0000),
  parameter logic [ADDR_W-1:0] ROM_START = ADDR_W'(32'h4000_0000),
  parameter logic [ADDR_W-1:0] ROM_LIMIT = ADDR_W'(32'h5000_0000)
) (
  input  logic [ADDR_W-1:0] phys,
  output logic [ADDR_W-1:0] mapped,
  output logic              isRom,
  output logic              isBad
);

  localparam logic [ADDR_W-1:0] ROM_MASK = ROM_BYTES - ADDR_W'(1);

  always_comb begin
    mapped = '0;
    isRom  = 1'b0;
    isBad  = 1'b0;
    if (phys < ROM_START) begin
      mapped = phys % RAM_BYTES;
    end else if (phys < ROM_LIMIT) begin
      mapped = phys & ROM_MASK;
      isRom  = 1'b1;
    end else begin
      isBad  = 1'b1;
    end
  end

endmodule

// File: rtl/fpb_datapath.sv
module fpb_datapath
  import fpb_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       PS_W      = 4,
  parameter logic [ADDR_W-1:0] RAM_BYTES = ADDR_W'(32'h0030_0000),
  parameter logic [ADDR_W-1:0] ROM_BYTES = ADDR_W'(32'h0004_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpb_strobe_t       strobe,
  output fpb_status_t       status,
  input  logic              xlatEnable,
  input  logic              supRootEn,
  input  logic [PS_W-1:0]   pageShift,
  input  logic              invalidateReq,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              fetchLong,
  input  logic              superMode,
  input  logic [ADDR_W-1:0] xlRespBase,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [2:0]        reqFc,
  output logic              outAddrErr,
  output logic              outAbort,
  output logic              outBusErr,
  output logic              outRom0,
  output logic [ADDR_W-1:0] outAddr0,
  output logic              outRom1,
  output logic [ADDR_W-1:0] outAddr1
);

  localparam int unsigned WORDS = 2;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] LONG_TAIL = ADDR_W'(3);

  // fetch context
  logic [ADDR_W-1:0] pcReg;
  logic              isLong, isSuper, secondHalf;

  // single-entry tag and payload
  logic [1:0]        tagRoot;
  logic [ADDR_W-1:0] tagPage, tagBase;

  // lookup
  logic [ADDR_W-1:0] offMask, curAddr, curPage, physCur, lastByte;
  logic [1:0]        curRoot;

  logic [ADDR_W-1:0] physWord   [WORDS];
  logic [ADDR_W-1:0] mappedWord [WORDS];
  logic              romWord    [WORDS];
  logic              badWord    [WORDS];

  // result registers
  logic [ADDR_W-1:0] resAddr [WORDS];
  logic              resRom  [WORDS];

  assign offMask  = (ADDR_W'(1) << pageShift) - ADDR_W'(1);
  assign curAddr  = secondHalf ? (pcReg + WORD_STEP) : pcReg;
  assign curPage  = curAddr & ~offMask;
  assign curRoot  = {1'b0, supRootEn & isSuper};
  assign physCur  = xlatEnable ? ((tagBase & ~offMask) | (curAddr & offMask)) : curAddr;
  assign lastByte = (pcReg & offMask) + LONG_TAIL;

  assign physWord[0] = physCur;
  assign physWord[1] = physCur + WORD_STEP;

  for (genvar g = 0; g < WORDS; g++) begin : g_map
    fpb_region_map #(
      .ADDR_W   (ADDR_W),
      .RAM_BYTES(RAM_BYTES),
      .ROM_BYTES(ROM_BYTES)
    ) u_map (
      .phys  (physWord[g]),
      .mapped(mappedWord[g]),
      .isRom (romWord[g]),
      .isBad (badWord[g])
    );
  end

  assign status.oddPc      = pcReg[0];
  assign status.hit        = (tagRoot == curRoot) && (tagPage == curPage);
  assign status.crossing   = (lastByte >> pageShift) != '0;
  assign status.isLong     = isLong;
  assign status.secondHalf = secondHalf;

  assign reqAddr = curAddr;
  assign reqFc   = isSuper ? FC_SUPER_CODE : FC_USER_CODE;

  // fetch context
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg      <= '0;
      isLong     <= 1'b0;
      isSuper    <= 1'b0;
      secondHalf <= 1'b0;
    end else if (strobe.accept) begin
      pcReg      <= fetchPc;
      isLong     <= fetchLong;
      isSuper    <= superMode;
      secondHalf <= 1'b0;
    end else if (strobe.advance) begin
      secondHalf <= 1'b1;
    end
  end

  // tag: emptying wins over a refill in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagRoot <= ROOT_EMPTY;
      tagPage <= '0;
      tagBase <= '0;
    end else if (invalidateReq || strobe.dropTag) begin
      tagRoot <= ROOT_EMPTY;
    end else if (strobe.refill) begin
      tagRoot <= curRoot;
      tagPage <= curPage;
      tagBase <= xlRespBase;
    end
  end

  // results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddrErr <= 1'b0;
      outAbort   <= 1'b0;
      outBusErr  <= 1'b0;
      for (int k = 0; k < WORDS; k++) begin
        resAddr[k] <= '0;
        resRom[k]  <= 1'b0;
      end
    end else if (strobe.accept) begin
      outAddrErr <= 1'b0;
      outAbort   <= 1'b0;
      outBusErr  <= 1'b0;
      for (int k = 0; k < WORDS; k++) begin
        resAddr[k] <= '0;
        resRom[k]  <= 1'b0;
      end
    end else if (strobe.markAbort) begin
      outAbort  <= 1'b1;
      outBusErr <= 1'b0;
      for (int k = 0; k < WORDS; k++) begin
        resAddr[k] <= '0;
        resRom[k]  <= 1'b0;
      end
    end else begin
      if (strobe.markOdd) outAddrErr <= 1'b1;
      if (strobe.captureCur) begin
        resAddr[secondHalf] <= badWord[0] ? '0 : mappedWord[0];
        resRom[secondHalf]  <= romWord[0] & ~badWord[0];
      end
      if (strobe.captureNext) begin
        resAddr[1] <= badWord[1] ? '0 : mappedWord[1];
        resRom[1]  <= romWord[1] & ~badWord[1];
      end
      if ((strobe.captureCur && badWord[0]) || (strobe.captureNext && badWord[1]))
        outBusErr <= 1'b1;
    end
  end

  assign outAddr0 = resAddr[0];
  assign outRom0  = resRom[0];
  assign outAddr1 = resAddr[1];
  assign outRom1  = resRom[1];

endmodule

// File: rtl/fpb_control.sv
module fpb_control
  import fpb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  fpb_status_t status,
  input  logic        xlatEnable,
  input  logic        fetchValid,
  input  logic        xlRespValid,
  input  logic        xlRespAbort,
  output fpb_strobe_t strobe,
  output logic        fetchReady,
  output logic        xlReqValid,
  output logic        doneValid
);

  fpb_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe     = '0;
    nextState  = state;
    fetchReady = 1'b0;
    xlReqValid = 1'b0;
    doneValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        fetchReady = 1'b1;
        if (fetchValid) begin
          strobe.accept = 1'b1;
          nextState     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!status.secondHalf && status.oddPc) begin
          strobe.markOdd = 1'b1;
          nextState      = ST_DONE;
        end else if (!xlatEnable) begin
          strobe.captureCur  = 1'b1;
          strobe.captureNext = status.isLong;
          nextState          = ST_DONE;
        end else if (status.hit) begin
          strobe.captureCur = 1'b1;
          if (!status.secondHalf && status.isLong) begin
            if (status.crossing) begin
              strobe.advance = 1'b1;
            end else begin
              strobe.captureNext = 1'b1;
              nextState          = ST_DONE;
            end
          end else begin
            nextState = ST_DONE;
          end
        end else begin
          xlReqValid = 1'b1;
          nextState  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (xlRespValid) begin
          if (xlRespAbort) begin
            strobe.markAbort = 1'b1;
            strobe.dropTag   = 1'b1;
            nextState        = ST_DONE;
          end else begin
            strobe.refill = 1'b1;
            nextState     = ST_CHECK;
          end
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/fetch_page_buffer.sv
module fetch_page_buffer
  import fpb_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       PS_W      = 4,
  parameter logic [ADDR_W-1:0] RAM_BYTES = ADDR_W'(32'h0030_0000),
  parameter logic [ADDR_W-1:0] ROM_BYTES = ADDR_W'(32'h0004_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xlatEnable,
  input  logic              supRootEn,
  input  logic [PS_W-1:0]   pageShift,
  input  logic              ctrlWrite,
  input  logic              flushPulse,
  input  logic              fetchValid,
  output logic              fetchReady,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic              fetchLong,
  input  logic              superMode,
  output logic              xlReqValid,
  output logic [ADDR_W-1:0] xlReqAddr,
  output logic [2:0]        xlReqFc,
  input  logic              xlRespValid,
  input  logic              xlRespAbort,
  input  logic [ADDR_W-1:0] xlRespBase,
  output logic              doneValid,
  output logic              doneAddrErr,
  output logic              doneAbort,
  output logic              doneBusErr,
  output logic              doneRom0,
  output logic [ADDR_W-1:0] doneAddr0,
  output logic              doneRom1,
  output logic [ADDR_W-1:0] doneAddr1
);

  fpb_strobe_t strobe;
  fpb_status_t status;

  fpb_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .status     (status),
    .xlatEnable (xlatEnable),
    .fetchValid (fetchValid),
    .xlRespValid(xlRespValid),
    .xlRespAbort(xlRespAbort),
    .strobe     (strobe),
    .fetchReady (fetchReady),
    .xlReqValid (xlReqValid),
    .doneValid  (doneValid)
  );

  fpb_datapath #(
    .ADDR_W   (ADDR_W),
    .PS_W     (PS_W),
    .RAM_BYTES(RAM_BYTES),
    .ROM_BYTES(ROM_BYTES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .status       (status),
    .xlatEnable   (xlatEnable),
    .supRootEn    (supRootEn),
    .pageShift    (pageShift),
    .invalidateReq(ctrlWrite | flushPulse),
    .fetchPc      (fetchPc),
    .fetchLong    (fetchLong),
    .superMode    (superMode),
    .xlRespBase   (xlRespBase),
    .reqAddr      (xlReqAddr),
    .reqFc        (xlReqFc),
    .outAddrErr   (doneAddrErr),
    .outAbort     (doneAbort),
    .outBusErr    (doneBusErr),
    .outRom0      (doneRom0),
    .outAddr0     (doneAddr0),
    .outRom1      (doneRom1),
    .outAddr1     (doneAddr1)
  );

endmodule

// File: rtl/fpb_checker.sv
module fpb_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchReady,
  input logic              xlReqValid,
  input logic [ADDR_W-1:0] xlReqAddr,
  input logic [2:0]        xlReqFc,
  input logic              doneValid,
  input logic              doneAddrErr,
  input logic              doneAbort,
  input logic              doneBusErr,
  input logic [ADDR_W-1:0] doneAddr0,
  input logic [ADDR_W-1:0] doneAddr1
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlReqValid |=> !xlReqValid);

  // R11
  busy_on_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlReqValid |-> !fetchReady);

  // R2
  req_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    xlReqValid |-> ((xlReqFc == 3'd6) || (xlReqFc == 3'd2)) && !xlReqAddr[0]);

  // R6
  odd_no_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneAddrErr) |-> (doneAddr0 == '0) && (doneAddr1 == '0) && !doneAbort);

  // R9
  abort_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneAbort) |-> !doneBusErr && (doneAddr0 == '0) && (doneAddr1 == '0));

  // R6
  odd_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneAddrErr) |-> !$past(xlReqValid));

endmodule

bind fetch_page_buffer fpb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fetchReady (fetchReady),
  .xlReqValid (xlReqValid),
  .xlReqAddr  (xlReqAddr),
  .xlReqFc    (xlReqFc),
  .doneValid  (doneValid),
  .doneAddrErr(doneAddrErr),
  .doneAbort  (doneAbort),
  .doneBusErr (doneBusErr),
  .doneAddr0  (doneAddr0),
  .doneAddr1  (doneAddr1)
);

// File: tb/fetch_page_buffer_bench.sv
`timescale 1ns/1ps
module fetch_page_buffer_bench;

  localparam int unsigned AW = 32;
  localparam logic [31:0] RAM_SZ = 32'h0030_0000;
  localparam logic [31:0] ROM_SZ = 32'h0004_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xlatEnable = 1'b1, supRootEn = 1'b1;
  logic [3:0] pageShift = 4'd12;
  logic ctrlWrite = 1'b0, flushPulse = 1'b0;
  logic fetchValid = 1'b0, fetchLong = 1'b0, superMode = 1'b0;
  logic [31:0] fetchPc = '0;
  logic xlRespValid = 1'b0, xlRespAbort = 1'b0;
  logic [31:0] xlRespBase = '0;
  logic fetchReady, xlReqValid, doneValid, doneAddrErr, doneAbort, doneBusErr, doneRom0, doneRom1;
  logic [31:0] xlReqAddr, doneAddr0, doneAddr1;
  logic [2:0] xlReqFc;

  always #5 clk = ~clk;

  fetch_page_buffer u_fetch_page_buffer (
    .clk(clk), .rstN(rstN), .xlatEnable(xlatEnable), .supRootEn(supRootEn),
    .pageShift(pageShift), .ctrlWrite(ctrlWrite), .flushPulse(flushPulse),
    .fetchValid(fetchValid), .fetchReady(fetchReady), .fetchPc(fetchPc),
    .fetchLong(fetchLong), .superMode(superMode), .xlReqValid(xlReqValid),
    .xlReqAddr(xlReqAddr), .xlReqFc(xlReqFc), .xlRespValid(xlRespValid),
    .xlRespAbort(xlRespAbort), .xlRespBase(xlRespBase), .doneValid(doneValid),
    .doneAddrErr(doneAddrErr), .doneAbort(doneAbort), .doneBusErr(doneBusErr),
    .doneRom0(doneRom0), .doneAddr0(doneAddr0), .doneRom1(doneRom1), .doneAddr1(doneAddr1)
  );

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  // results of the last fetch
  int          gotReqs;
  bit          gotDone, gotReadyLow;
  logic [31:0] lastReqAddr, gAddr0, gAddr1;
  logic        gOdd, gAbort, gBus, gRom0, gRom1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // translation model of the bench: user and supervisor codes map differently
  function automatic logic [31:0] xlModel(input logic [31:0] a, input bit sup);
    return sup ? ((a & 32'h000F_FFFF) | 32'h4000_0000) : (a + 32'h0010_0000);
  endfunction

  task automatic mapExp(input logic [31:0] p, output logic [31:0] m, output logic rom, output logic bad);
    m = '0; rom = 1'b0; bad = 1'b0;
    if (p < 32'h4000_0000)      m = p % RAM_SZ;
    else if (p < 32'h5000_0000) begin m = p & (ROM_SZ - 1); rom = 1'b1; end
    else bad = 1'b1;
  endtask

  task automatic runFetch(input logic [31:0] pc, input bit lng, input bit sup);
    gotReqs = 0; gotDone = 0; gotReadyLow = 0;
    @(negedge clk);
    fetchPc = pc; fetchLong = lng; superMode = sup; fetchValid = 1'b1;
    @(negedge clk);
    fetchValid = 1'b0;
    gotReadyLow = !fetchReady;
    for (int i = 0; i < 40 && !gotDone; i++) begin
      if (doneValid) begin
        gotDone = 1;
        gOdd = doneAddrErr; gAbort = doneAbort; gBus = doneBusErr;
        gAddr0 = doneAddr0; gRom0 = doneRom0; gAddr1 = doneAddr1; gRom1 = doneRom1;
      end else if (xlReqValid) begin
        gotReqs++;
        lastReqAddr = xlReqAddr;
        chk("R2 request function code", {29'b0, xlReqFc}, sup ? 32'd6 : 32'd2);
        @(negedge clk);
        xlRespValid = 1'b1;
        xlRespBase  = xlModel(lastReqAddr, sup);
        xlRespAbort = (lastReqAddr[31:28] == 4'hE);
        @(negedge clk);
        xlRespValid = 1'b0; xlRespAbort = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    if (!gotDone) begin
      nChecks++; nFail++;
      $display("FAIL R11 no done pulse actual=0 expected=1");
    end
  endtask

  task automatic pulseCtrl(input bit flush);
    @(negedge clk);
    if (flush) flushPulse = 1'b1; else ctrlWrite = 1'b1;
    @(negedge clk);
    flushPulse = 1'b0; ctrlWrite = 1'b0;
  endtask

  // generic expected-value check of the last fetch
  task automatic checkFetch(input string tag, input logic [31:0] pc, input bit lng, input bit sup, input int expReqs);
    logic [31:0] p0, p1, m0, m1;
    logic r0, r1, b0, b1, expAbort, expOdd;
    expOdd   = pc[0];
    expAbort = xlatEnable && !expOdd && (pc[31:28] == 4'hE);
    p0 = xlatEnable ? xlModel(pc, sup) : pc;
    p1 = xlatEnable ? xlModel(pc + 32'd2, sup) : pc + 32'd2;
    mapExp(p0, m0, r0, b0);
    mapExp(p1, m1, r1, b1);
    if (b0) begin m0 = '0; r0 = 1'b0; end
    if (!lng || b1) begin m1 = '0; r1 = 1'b0; end
    if (!lng) b1 = 1'b0;
    if (expOdd || expAbort) begin m0 = '0; m1 = '0; r0 = 1'b0; r1 = 1'b0; b0 = 1'b0; b1 = 1'b0; end
    chk({tag, " R1/R2 request count"}, gotReqs, expReqs);
    chk({tag, " R6 odd flag"}, {31'b0, gOdd}, {31'b0, expOdd});
    chk({tag, " R9 abort flag"}, {31'b0, gAbort}, {31'b0, expAbort});
    chk({tag, " R8 bus error"}, {31'b0, gBus}, {31'b0, b0 | b1});
    chk({tag, " R8 word0 address"}, gAddr0, m0);
    chk({tag, " R8 word0 rom"}, {31'b0, gRom0}, {31'b0, r0});
    chk({tag, " R5 word1 address"}, gAddr1, m1);
    chk({tag, " R5 word1 rom"}, {31'b0, gRom1}, {31'b0, r1});
  endtask

  typedef struct packed {
    logic [31:0] pc;
    logic        lng;
    logic        sup;
    logic [1:0]  reqs;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 1'b0, 1'b0, 2'd1},  // R2 cold miss
    '{32'h0000_1002, 1'b1, 1'b0, 2'd0},  // R1 hit, long
    '{32'h0000_1FFC, 1'b1, 1'b0, 2'd0},  // R5 long ends exactly at page end
    '{32'h0000_1FFE, 1'b1, 1'b0, 2'd1},  // R5 split, second word misses
    '{32'h0000_2010, 1'b0, 1'b1, 2'd1},  // R3 supervisor root differs
    '{32'h0000_2010, 1'b0, 1'b0, 2'd1},  // R3 back to user root
    '{32'h0030_0100, 1'b0, 1'b0, 2'd1},  // R8 RAM modulo wrap
    '{32'h4000_0000, 1'b0, 1'b1, 2'd1},  // R8 ROM base
    '{32'h4003_F002, 1'b1, 1'b1, 2'd1},  // R8 ROM mask, long
    '{32'h5000_0000, 1'b0, 1'b0, 2'd1},  // R8 bus error
    '{32'h0000_3001, 1'b0, 1'b0, 2'd0},  // R6 odd
    '{32'hE000_0000, 1'b0, 1'b0, 2'd1},  // R9 abort
    '{32'h5000_0002, 1'b0, 1'b0, 2'd1},  // R9 entry empty after abort
    '{32'h5000_0007, 1'b0, 1'b0, 2'd0},  // R6 odd leaves tag
    '{32'h5000_0004, 1'b1, 1'b0, 2'd0},  // R6 tag intact -> hit
    '{32'h0000_1FFE, 1'b1, 1'b1, 2'd2}   // R5 split, both words miss
  };

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nFail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset fetchReady", {31'b0, fetchReady}, 32'd1);
    chk("R11 reset doneValid", {31'b0, doneValid}, 32'd0);
    chk("R11 reset xlReqValid", {31'b0, xlReqValid}, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      runFetch(VECS[v].pc, VECS[v].lng, VECS[v].sup);
      checkFetch($sformatf("vec%0d", v), VECS[v].pc, VECS[v].lng, VECS[v].sup, int'(VECS[v].reqs));
    end
    chk("R11 busy while fetching", {31'b0, gotReadyLow}, 32'd1);

    // R4 control write empties the entry
    runFetch(32'h0000_1000, 1'b0, 1'b0);
    runFetch(32'h0000_1000, 1'b0, 1'b0);
    chk("R1 refetch hits", gotReqs, 0);
    pulseCtrl(1'b0);
    runFetch(32'h0000_1000, 1'b0, 1'b0);
    chk("R4 miss after ctrlWrite", gotReqs, 1);
    // R4 flush
    pulseCtrl(1'b1);
    runFetch(32'h0000_1000, 1'b0, 1'b0);
    chk("R4 miss after flushPulse", gotReqs, 1);
    // R4 reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    runFetch(32'h0000_1000, 1'b0, 1'b0);
    checkFetch("R4 after reset", 32'h0000_1000, 1'b0, 1'b0, 1);

    // R7 bypass with translation off
    xlatEnable = 1'b0;
    runFetch(32'h0031_0000, 1'b1, 1'b0);
    checkFetch("R7 bypass RAM", 32'h0031_0000, 1'b1, 1'b0, 0);
    runFetch(32'h4004_0010, 1'b0, 1'b1);
    checkFetch("R7 bypass ROM", 32'h4004_0010, 1'b0, 1'b1, 0);
    runFetch(32'h6000_0000, 1'b0, 1'b0);
    checkFetch("R7 bypass bus error", 32'h6000_0000, 1'b0, 1'b0, 0);
    xlatEnable = 1'b1;

    // R10 smaller page: same PC now splits
    pageShift = 4'd8;
    pulseCtrl(1'b0);
    runFetch(32'h0000_10FE, 1'b1, 1'b0);
    checkFetch("R10 split at 256B page", 32'h0000_10FE, 1'b1, 1'b0, 2);
    chk("R2 second request address", lastReqAddr, 32'h0000_1100);
    runFetch(32'h0000_10FC, 1'b1, 1'b0);
    checkFetch("R10 fits in 256B page", 32'h0000_10FC, 1'b1, 1'b0, 1);
    pageShift = 4'd12;
    pulseCtrl(1'b0);

    // R3 shared entry when supervisor root disabled
    supRootEn = 1'b0;
    pulseCtrl(1'b0);
    runFetch(32'h0000_3000, 1'b0, 1'b1);
    chk("R3 supervisor fill request", gotReqs, 1);
    chk("R3 supervisor word ROM", {31'b0, gRom0}, 32'd1);
    runFetch(32'h0000_3002, 1'b0, 1'b0);
    chk("R3 user reuses supervisor entry", gotReqs, 0);
    chk("R3 user gets cached ROM address", gAddr0, 32'h0000_3002);
    chk("R3 user gets cached ROM flag", {31'b0, gRom0}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule